// File: doc/BRIEF.md
# Programmable Colour Combiner Stage

This block is one stage of a per-pixel shading datapath. Each cycle that a vector is presented, it reads a small file of RGBA registers and two constant colours, and it computes three RGB results and three scalar results. All values are signed fixed point with `FRAC` fraction bits, so `1.0` is the code `2^FRAC`. The results are captured in one output register stage so that a write-back path can store them.

The RGB half picks four three-lane inputs, called A, B, C and D. Each input comes either from a source's colour lanes or from its alpha replicated across the three lanes. Each input then passes through one of eight range mappings. The first result is formed from A and B, and the second from C and D. Each is either a lane-wise product or a dot product replicated into all three lanes. The third result is either the sum of the first two or a choice between them, and that choice is steered by the alpha of one designated spare register. A dot product in either of the first two results suppresses the third. One scale/bias setting applies to all three outputs, and each output saturates to [-1, 1]. The alpha half does the same on scalars: each input comes from a source's alpha or blue lane, there are no dot products, and it has its own scale/bias setting.

There is no control state machine. The only state is the output register bank and its valid flag. It has two conditions: IDLE (`out_valid` low, results held) and LOADED (`out_valid` high). The transition IDLE→LOADED and the transition LOADED→LOADED are both taken on a clock edge with `in_valid` high. The transition to IDLE is taken on any edge with `in_valid` low.

Top module: `shade_combiner`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first accepted vector, `out_valid`, `out_third_rgb_en` and every result port read zero.
- R2: A vector presented with `in_valid` high at a rising edge appears on the result ports, with `out_valid` high, right after that edge. At an edge with `in_valid` low, `out_valid` drops and every result port keeps its previous value.
- R3: Source codes 0 to NREG-1 pick register file entries, code NREG picks constant `k0_rgba`, and code NREG+1 picks `k1_rgba`. Inside every RGBA word, lane 0 is red, 1 is green, 2 is blue and 3 is alpha, and each lane is W bits. When `rgb_from_alpha[i]` is set, RGB input i carries lane 3 on all three lanes. When `a_from_blue[i]` is set, alpha input i carries lane 2 instead of lane 3.
- R4: The mapping codes, with u = max(x, 0), are: 0 u; 1 1-u; 2 2u-1; 3 1-2u; 4 u-0.5; 5 0.5-u; 6 x; 7 -x.
- R5: A non-dot result is the lane-wise product of its mapped pair, with the fractional product rounded toward minus infinity. A dot result (`rgb_ab_dot` for A·B, `rgb_cd_dot` for C·D) is the sum of the three lane products, and it appears on all three lanes.
- R6: With the mux select clear, the third result is the sum of the first two before scaling.
- R7: With the mux select set, the third result equals the first result when the spare register's alpha is below 0.5, and equals the second result otherwise. The same rule steers the alpha half.
- R8: When either RGB dot select is set, `out_third_rgb_en` is low and `out_third_rgb` reads zero. Otherwise `out_third_rgb_en` is high.
- R9: The scale codes are: 0 none; 1 ×2; 2 ×4; 3 ÷2 rounded toward minus infinity; 4 subtract 0.5; 5 subtract 0.5 and then ×2. Codes 6 and 7 act as none.
- R10: Every result is clamped to the range [-1.0, +1.0] after scaling.
- R11: The alpha half applies R4, the product of R5 (without dot), R6, R7, R9 and R10 to scalar inputs, using `a_map` and `a_scale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vector present this cycle |
| rf_flat | input | NREG*4*W | Register file, entry r lane l at bits (r*4+l)*W |
| k0_rgba | input | 4*W | Constant colour 0 |
| k1_rgba | input | 4*W | Constant colour 1 |
| rgb_sel | input | 4*SELW | Source code for RGB inputs A..D |
| rgb_from_alpha | input | 4 | Replicate alpha into RGB input |
| rgb_map | input | 4*3 | Mapping code per RGB input |
| rgb_ab_dot | input | 1 | First RGB result is A·B |
| rgb_cd_dot | input | 1 | Second RGB result is C·D |
| rgb_third_mux | input | 1 | Third RGB result is a mux, not a sum |
| rgb_scale | input | 3 | RGB scale/bias code |
| a_sel | input | 4*SELW | Source code for alpha inputs A..D |
| a_from_blue | input | 4 | Alpha input takes the blue lane |
| a_map | input | 4*3 | Mapping code per alpha input |
| a_third_mux | input | 1 | Third alpha result is a mux |
| a_scale | input | 3 | Alpha scale/bias code |
| out_valid | output | 1 | Results hold a new vector |
| out_ab_rgb | output | 3*W | First RGB result |
| out_cd_rgb | output | 3*W | Second RGB result |
| out_third_rgb | output | 3*W | Third RGB result |
| out_third_rgb_en | output | 1 | Third RGB result may be written back |
| out_ab_a | output | W | First alpha result |
| out_cd_a | output | W | Second alpha result |
| out_third_a | output | W | Third alpha result |

## Verification
The design has no state other than its result registers, so a wrong mapping, product or scale shows up as a wrong value on the very next cycle after the offending vector. A mux that reads the wrong spare lane, or a suppression that misses, shows up in the third result in that same cycle. The stimulus sweeps every mapping and scale code across a grid of input values that includes both rails and the 0.5 threshold of the spare alpha, so that each of these faults gives a value mismatch. An idle cycle checks the hold behaviour: results that drift when no vector is accepted show up one cycle later.

// File: rtl/shcomb_pkg.sv
package shcomb_pkg;

    typedef enum logic [2:0] {
        MAP_U_ID    = 3'd0,
        MAP_U_INV   = 3'd1,
        MAP_EXP     = 3'd2,
        MAP_EXP_NEG = 3'd3,
        MAP_HB      = 3'd4,
        MAP_HB_NEG  = 3'd5,
        MAP_S_ID    = 3'd6,
        MAP_S_NEG   = 3'd7
    } map_e;

    typedef enum logic [2:0] {
        SB_NONE    = 3'd0,
        SB_X2      = 3'd1,
        SB_X4      = 3'd2,
        SB_HALF    = 3'd3,
        SB_BIAS    = 3'd4,
        SB_BIAS_X2 = 3'd5
    } scl_e;

endpackage

// File: rtl/shcomb_map.sv
module shcomb_map
    import shcomb_pkg::*;
#(
    parameter int W    = 10,
    parameter int FRAC = 8
) (
    input  logic [2:0]   code,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    localparam int EW = W + 2;
    localparam logic signed [EW-1:0] ONE_E  = EW'(1 << FRAC);
    localparam logic signed [EW-1:0] HALF_E = EW'(1 << (FRAC - 1));

    logic signed [EW-1:0] xs;
    logic signed [EW-1:0] us;
    logic signed [EW-1:0] r;

    always_comb begin
        xs = EW'($signed(x));
        us = (xs < 0) ? '0 : xs;
        unique case (map_e'(code))
            MAP_U_ID:    r = us;
            MAP_U_INV:   r = ONE_E - us;
            MAP_EXP:     r = (us <<< 1) - ONE_E;
            MAP_EXP_NEG: r = ONE_E - (us <<< 1);
            MAP_HB:      r = us - HALF_E;
            MAP_HB_NEG:  r = HALF_E - us;
            MAP_S_ID:    r = xs;
            MAP_S_NEG:   r = -xs;
        endcase
        y = r[W-1:0];
    end

endmodule

// File: rtl/shcomb_scale.sv
module shcomb_scale
    import shcomb_pkg::*;
#(
    parameter int W    = 10,
    parameter int FRAC = 8,
    parameter int IW   = 14
) (
    input  logic [2:0]          code,
    input  logic signed [IW-1:0] x,
    output logic [W-1:0]        y
);
    localparam int TW = IW + 2;
    localparam logic signed [TW-1:0] ONE_T  = TW'(1 << FRAC);
    localparam logic signed [TW-1:0] HALF_T = TW'(1 << (FRAC - 1));
    localparam logic signed [TW-1:0] NEG_T  = -ONE_T;

    logic signed [TW-1:0] xe;
    logic signed [TW-1:0] t;

    always_comb begin
        xe = TW'(x);
        case (scl_e'(code))
            SB_X2:      t = xe <<< 1;
            SB_X4:      t = xe <<< 2;
            SB_HALF:    t = xe >>> 1;
            SB_BIAS:    t = xe - HALF_T;
            SB_BIAS_X2: t = (xe - HALF_T) <<< 1;
            default:    t = xe;
        endcase
        if (t > ONE_T)       y = ONE_T[W-1:0];
        else if (t < NEG_T)  y = NEG_T[W-1:0];
        else                 y = t[W-1:0];
    end

endmodule

// File: rtl/shcomb_rgb.sv
module shcomb_rgb #(
    parameter int W    = 10,
    parameter int FRAC = 8,
    parameter int IW   = 14
) (
    input  logic [3:0][2:0][W-1:0] src,
    input  logic [3:0][2:0]        map_code,
    input  logic                   ab_dot,
    input  logic                   cd_dot,
    input  logic                   third_mux,
    input  logic                   pick_cd,
    input  logic [2:0]             scale,
    output logic [2:0][W-1:0]      ab_o,
    output logic [2:0][W-1:0]      cd_o,
    output logic [2:0][W-1:0]      third_o,
    output logic                   third_en
);
    logic [W-1:0]         mv   [4][3];
    logic signed [IW-1:0] pab  [3];
    logic signed [IW-1:0] pcd  [3];
    logic signed [IW-1:0] rab  [3];
    logic signed [IW-1:0] rcd  [3];
    logic signed [IW-1:0] rth  [3];
    logic [W-1:0]         sab  [3];
    logic [W-1:0]         scd  [3];
    logic [W-1:0]         sth  [3];
    logic signed [IW-1:0] dab;
    logic signed [IW-1:0] dcd;

    // input mapping network: four inputs by three lanes
    for (genvar i = 0; i < 4; i++) begin : g_in
        for (genvar l = 0; l < 3; l++) begin : g_lane
            shcomb_map #(.W(W), .FRAC(FRAC)) u_map (
                .code (map_code[i]),
                .x    (src[i][l]),
                .y    (mv[i][l])
            );
        end
    end

    // lane products
    for (genvar l = 0; l < 3; l++) begin : g_prod
        logic signed [2*W-1:0] fab;
        logic signed [2*W-1:0] fcd;
        assign fab    = $signed(mv[0][l]) * $signed(mv[1][l]);
        assign fcd    = $signed(mv[2][l]) * $signed(mv[3][l]);
        assign pab[l] = IW'(fab >>> FRAC);
        assign pcd[l] = IW'(fcd >>> FRAC);
    end

    always_comb begin
        dab = pab[0] + pab[1] + pab[2];
        dcd = pcd[0] + pcd[1] + pcd[2];
        for (int l = 0; l < 3; l++) begin
            rab[l] = ab_dot ? dab : pab[l];
            rcd[l] = cd_dot ? dcd : pcd[l];
            if (third_mux) rth[l] = pick_cd ? rcd[l] : rab[l];
            else           rth[l] = rab[l] + rcd[l];
        end
    end

    // shared scale/bias on all three outputs
    for (genvar l = 0; l < 3; l++) begin : g_scl
        shcomb_scale #(.W(W), .FRAC(FRAC), .IW(IW)) u_sab (
            .code (scale), .x (rab[l]), .y (sab[l])
        );
        shcomb_scale #(.W(W), .FRAC(FRAC), .IW(IW)) u_scd (
            .code (scale), .x (rcd[l]), .y (scd[l])
        );
        shcomb_scale #(.W(W), .FRAC(FRAC), .IW(IW)) u_sth (
            .code (scale), .x (rth[l]), .y (sth[l])
        );
    end

    always_comb begin
        third_en = !(ab_dot || cd_dot);
        for (int l = 0; l < 3; l++) begin
            ab_o[l]    = sab[l];
            cd_o[l]    = scd[l];
            third_o[l] = third_en ? sth[l] : '0;
        end
    end

endmodule

// File: rtl/shcomb_alpha.sv
module shcomb_alpha #(
    parameter int W    = 10,
    parameter int FRAC = 8,
    parameter int IW   = 14
) (
    input  logic [3:0][W-1:0] src,
    input  logic [3:0][2:0]   map_code,
    input  logic              third_mux,
    input  logic              pick_cd,
    input  logic [2:0]        scale,
    output logic [W-1:0]      ab_o,
    output logic [W-1:0]      cd_o,
    output logic [W-1:0]      third_o
);
    logic [W-1:0]          mv [4];
    logic signed [2*W-1:0] fab;
    logic signed [2*W-1:0] fcd;
    logic signed [IW-1:0]  rab;
    logic signed [IW-1:0]  rcd;
    logic signed [IW-1:0]  rth;

    for (genvar i = 0; i < 4; i++) begin : g_in
        shcomb_map #(.W(W), .FRAC(FRAC)) u_map (
            .code (map_code[i]),
            .x    (src[i]),
            .y    (mv[i])
        );
    end

    always_comb begin
        fab = $signed(mv[0]) * $signed(mv[1]);
        fcd = $signed(mv[2]) * $signed(mv[3]);
        rab = IW'(fab >>> FRAC);
        rcd = IW'(fcd >>> FRAC);
        rth = third_mux ? (pick_cd ? rcd : rab) : (rab + rcd);
    end

    shcomb_scale #(.W(W), .FRAC(FRAC), .IW(IW)) u_sab (
        .code (scale), .x (rab), .y (ab_o)
    );
    shcomb_scale #(.W(W), .FRAC(FRAC), .IW(IW)) u_scd (
        .code (scale), .x (rcd), .y (cd_o)
    );
    shcomb_scale #(.W(W), .FRAC(FRAC), .IW(IW)) u_sth (
        .code (scale), .x (rth), .y (third_o)
    );

endmodule

// File: rtl/shade_combiner.sv
module shade_combiner #(
    parameter int NREG      = 6,
    parameter int FRAC      = 8,
    parameter int SPARE_IDX = 0,
    localparam int W        = FRAC + 2,
    localparam int IW       = W + 4,
    localparam int SELW     = $clog2(NREG + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NREG*4*W-1:0]      rf_flat,
    input  logic [4*W-1:0]           k0_rgba,
    input  logic [4*W-1:0]           k1_rgba,
    input  logic [3:0][SELW-1:0]     rgb_sel,
    input  logic [3:0]               rgb_from_alpha,
    input  logic [3:0][2:0]          rgb_map,
    input  logic                     rgb_ab_dot,
    input  logic                     rgb_cd_dot,
    input  logic                     rgb_third_mux,
    input  logic [2:0]               rgb_scale,
    input  logic [3:0][SELW-1:0]     a_sel,
    input  logic [3:0]               a_from_blue,
    input  logic [3:0][2:0]          a_map,
    input  logic                     a_third_mux,
    input  logic [2:0]               a_scale,
    output logic                     out_valid,
    output logic [2:0][W-1:0]        out_ab_rgb,
    output logic [2:0][W-1:0]        out_cd_rgb,
    output logic [2:0][W-1:0]        out_third_rgb,
    output logic                     out_third_rgb_en,
    output logic [W-1:0]             out_ab_a,
    output logic [W-1:0]             out_cd_a,
    output logic [W-1:0]             out_third_a
);
    localparam logic signed [W-1:0] HALF_W = W'(1 << (FRAC - 1));

    function automatic logic [W-1:0] fetch(
        input logic [SELW-1:0]     s,
        input logic [1:0]          lane,
        input logic [NREG*4*W-1:0] rf,
        input logic [4*W-1:0]      c0,
        input logic [4*W-1:0]      c1
    );
        int idx;
        idx = int'(s);
        if (idx < NREG)          return rf[(idx*4 + int'(lane))*W +: W];
        else if (idx == NREG)    return c0[int'(lane)*W +: W];
        else if (idx == NREG+1)  return c1[int'(lane)*W +: W];
        else                     return '0;
    endfunction

    logic [3:0][2:0][W-1:0] rgb_in;
    logic [3:0][W-1:0]      a_in;
    logic [W-1:0]           spare_alpha;
    logic                   pick_cd;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            for (int l = 0; l < 3; l++) begin
                rgb_in[i][l] = fetch(rgb_sel[i],
                                     rgb_from_alpha[i] ? 2'd3 : 2'(l),
                                     rf_flat, k0_rgba, k1_rgba);
            end
            a_in[i] = fetch(a_sel[i], a_from_blue[i] ? 2'd2 : 2'd3,
                            rf_flat, k0_rgba, k1_rgba);
        end
        spare_alpha = rf_flat[(SPARE_IDX*4 + 3)*W +: W];
        pick_cd     = !($signed(spare_alpha) < HALF_W);
    end

    logic [2:0][W-1:0] n_ab_rgb;
    logic [2:0][W-1:0] n_cd_rgb;
    logic [2:0][W-1:0] n_third_rgb;
    logic              n_third_en;
    logic [W-1:0]      n_ab_a;
    logic [W-1:0]      n_cd_a;
    logic [W-1:0]      n_third_a;

    shcomb_rgb #(.W(W), .FRAC(FRAC), .IW(IW)) u_rgb (
        .src       (rgb_in),
        .map_code  (rgb_map),
        .ab_dot    (rgb_ab_dot),
        .cd_dot    (rgb_cd_dot),
        .third_mux (rgb_third_mux),
        .pick_cd   (pick_cd),
        .scale     (rgb_scale),
        .ab_o      (n_ab_rgb),
        .cd_o      (n_cd_rgb),
        .third_o   (n_third_rgb),
        .third_en  (n_third_en)
    );

    shcomb_alpha #(.W(W), .FRAC(FRAC), .IW(IW)) u_alpha (
        .src       (a_in),
        .map_code  (a_map),
        .third_mux (a_third_mux),
        .pick_cd   (pick_cd),
        .scale     (a_scale),
        .ab_o      (n_ab_a),
        .cd_o      (n_cd_a),
        .third_o   (n_third_a)
    );

    // result register bank: IDLE (out_valid low) / LOADED (out_valid high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= 1'b0;
            out_ab_rgb       <= '0;
            out_cd_rgb       <= '0;
            out_third_rgb    <= '0;
            out_third_rgb_en <= 1'b0;
            out_ab_a         <= '0;
            out_cd_a         <= '0;
            out_third_a      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_ab_rgb       <= n_ab_rgb;
                out_cd_rgb       <= n_cd_rgb;
                out_third_rgb    <= n_third_rgb;
                out_third_rgb_en <= n_third_en;
                out_ab_a         <= n_ab_a;
                out_cd_a         <= n_cd_a;
                out_third_a      <= n_third_a;
            end
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_ab_rgb) && $stable(out_third_rgb)
                       && $stable(out_third_a)));

    a_r8_dot_kills_third: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (rgb_ab_dot || rgb_cd_dot)) |=> (!out_third_rgb_en && out_third_rgb == '0));

    a_r5_dot_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rgb_ab_dot) |=> (out_ab_rgb[0] == out_ab_rgb[1] && out_ab_rgb[1] == out_ab_rgb[2]));

    a_r7_rgb_mux_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rgb_third_mux && !rgb_ab_dot && !rgb_cd_dot)
        |=> (out_third_rgb == ($past(pick_cd) ? out_cd_rgb : out_ab_rgb)));

    a_r11_alpha_mux_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_third_mux) |=> (out_third_a == ($past(pick_cd) ? out_cd_a : out_ab_a)));

endmodule

// File: tb/shade_combiner_bench.sv
module shade_combiner_bench;
    localparam int NREG = 6, FRAC = 8, W = 10, SELW = 3, SPARE = 0;
    localparam int ONE = 256, HALF = 128;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n, in_valid;
    logic [NREG*4*W-1:0]  rf_flat;
    logic [4*W-1:0]       k0_rgba, k1_rgba;
    logic [3:0][SELW-1:0] rgb_sel, a_sel;
    logic [3:0]           rgb_from_alpha, a_from_blue;
    logic [3:0][2:0]      rgb_map, a_map;
    logic                 rgb_ab_dot, rgb_cd_dot, rgb_third_mux, a_third_mux;
    logic [2:0]           rgb_scale, a_scale;
    logic                 out_valid, out_third_rgb_en;
    logic [2:0][W-1:0]    out_ab_rgb, out_cd_rgb, out_third_rgb;
    logic [W-1:0]         out_ab_a, out_cd_a, out_third_a;

    shade_combiner u_shade_combiner (.*);

    int rf [NREG][4];
    int k0v [4];
    int k1v [4];
    int rsel [4]; bit ralpha [4]; int rmap [4];
    int asel [4]; bit ablue [4];  int amap [4];
    bit abdot, cddot, rmux, amux;
    int rscale, ascale;
    int checks = 0, fails = 0;
    bit done = 0;
    int e_ab [3]; int e_cd [3]; int e_th [3];
    int e_en, e_aab, e_acd, e_ath;

    function automatic int fetchv(int s, int lane);
        if (s < NREG) return rf[s][lane];
        else if (s == NREG) return k0v[lane];
        else return k1v[lane];
    endfunction

    function automatic int mapf(int code, int x);
        int u = (x < 0) ? 0 : x;
        case (code)
            0: return u;
            1: return ONE - u;
            2: return 2*u - ONE;
            3: return ONE - 2*u;
            4: return u - HALF;
            5: return HALF - u;
            6: return x;
            default: return -x;
        endcase
    endfunction

    function automatic int scalef(int code, int x);
        int t;
        case (code)
            1: t = 2*x;
            2: t = 4*x;
            3: t = x >>> 1;
            4: t = x - HALF;
            5: t = 2*(x - HALF);
            default: t = x;
        endcase
        if (t > ONE) t = ONE;
        if (t < -ONE) t = -ONE;
        return t;
    endfunction

    task automatic drive();
        for (int r = 0; r < NREG; r++)
            for (int l = 0; l < 4; l++) rf_flat[(r*4+l)*W +: W] = W'(rf[r][l]);
        for (int l = 0; l < 4; l++) begin
            k0_rgba[l*W +: W] = W'(k0v[l]);
            k1_rgba[l*W +: W] = W'(k1v[l]);
        end
        for (int i = 0; i < 4; i++) begin
            rgb_sel[i] = SELW'(rsel[i]); rgb_from_alpha[i] = ralpha[i]; rgb_map[i] = 3'(rmap[i]);
            a_sel[i] = SELW'(asel[i]); a_from_blue[i] = ablue[i]; a_map[i] = 3'(amap[i]);
        end
        rgb_ab_dot = abdot; rgb_cd_dot = cddot; rgb_third_mux = rmux; a_third_mux = amux;
        rgb_scale = 3'(rscale); a_scale = 3'(ascale);
    endtask

    task automatic model();
        int m [4][3];
        int ma [4];
        int pa [3]; int pc [3]; int th [3];
        int da, dc, ra, rc, rt;
        bit pick = !(rf[SPARE][3] < HALF);
        for (int i = 0; i < 4; i++) begin
            for (int l = 0; l < 3; l++) m[i][l] = mapf(rmap[i], fetchv(rsel[i], ralpha[i] ? 3 : l));
            ma[i] = mapf(amap[i], fetchv(asel[i], ablue[i] ? 2 : 3));
        end
        da = 0; dc = 0;
        for (int l = 0; l < 3; l++) begin
            pa[l] = (m[0][l]*m[1][l]) >>> FRAC;
            pc[l] = (m[2][l]*m[3][l]) >>> FRAC;
            da += pa[l]; dc += pc[l];
        end
        for (int l = 0; l < 3; l++) begin
            if (abdot) pa[l] = da;
            if (cddot) pc[l] = dc;
            th[l] = rmux ? (pick ? pc[l] : pa[l]) : pa[l] + pc[l];
            e_ab[l] = scalef(rscale, pa[l]);
            e_cd[l] = scalef(rscale, pc[l]);
            e_th[l] = (abdot || cddot) ? 0 : scalef(rscale, th[l]);
        end
        e_en = (abdot || cddot) ? 0 : 1;
        ra = (ma[0]*ma[1]) >>> FRAC;
        rc = (ma[2]*ma[3]) >>> FRAC;
        rt = amux ? (pick ? rc : ra) : ra + rc;
        e_aab = scalef(ascale, ra); e_acd = scalef(ascale, rc); e_ath = scalef(ascale, rt);
    endtask

    task automatic cmp(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int l = 0; l < 3; l++) begin
            cmp(tag, $sformatf("ab_rgb[%0d]", l), int'($signed(out_ab_rgb[l])), e_ab[l]);
            cmp(tag, $sformatf("cd_rgb[%0d]", l), int'($signed(out_cd_rgb[l])), e_cd[l]);
            cmp(tag, $sformatf("third_rgb[%0d]", l), int'($signed(out_third_rgb[l])), e_th[l]);
        end
        cmp(tag, "third_rgb_en", int'(out_third_rgb_en), e_en);
        cmp(tag, "ab_a", int'($signed(out_ab_a)), e_aab);
        cmp(tag, "cd_a", int'($signed(out_cd_a)), e_acd);
        cmp(tag, "third_a", int'($signed(out_third_a)), e_ath);
    endtask

    task automatic run(string tag);
        @(negedge clk);
        drive();
        model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        compare_all(tag);
        cmp(tag, "valid", int'(out_valid), 1);
    endtask

    task automatic base();
        for (int r = 0; r < NREG; r++)
            for (int l = 0; l < 4; l++) rf[r][l] = (r*37 + l*29) % 400 - 200;
        rf[SPARE][3] = 0;
        for (int l = 0; l < 4; l++) begin k0v[l] = ONE; k1v[l] = -96 + 40*l; end
        rsel = '{1, NREG, NREG, NREG}; ralpha = '{0, 0, 0, 0}; rmap = '{6, 6, 6, 6};
        asel = '{1, NREG, NREG, NREG}; ablue = '{0, 0, 0, 0}; amap = '{6, 6, 6, 6};
        abdot = 0; cddot = 0; rmux = 0; amux = 0; rscale = 0; ascale = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0;
        base(); drive();
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "valid", int'(out_valid), 0);
        cmp("R1", "third_rgb_en", int'(out_third_rgb_en), 0);
        cmp("R1", "ab_rgb", int'(out_ab_rgb), 0);
        cmp("R1", "third_a", int'(out_third_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1", "valid after release", int'(out_valid), 0);
        cmp("R1", "cd_rgb after release", int'(out_cd_rgb), 0);

        // R4: every mapping across the input range
        for (int c = 0; c < 8; c++) begin
            for (int v = -256; v <= 256; v += 16) begin
                base();
                for (int l = 0; l < 4; l++) rf[1][l] = v;
                rmap[0] = c; amap[0] = c; rmap[2] = c; rsel[2] = 1;
                run("R4");
            end
        end

        // R5 R6: product grid, sum third
        for (int a = -256; a <= 256; a += 32) begin
            for (int b = -256; b <= 256; b += 32) begin
                base();
                for (int l = 0; l < 4; l++) begin rf[1][l] = a; rf[2][l] = b - 8*l; end
                rsel[1] = 2; asel[1] = 2; rsel[2] = 2; rsel[3] = 1;
                run("R5_R6");
            end
        end

        // R5 R8: dot products replicate and suppress the third result
        for (int k = 0; k < 12; k++) begin
            base();
            for (int l = 0; l < 4; l++) begin rf[1][l] = 60*l - 90 + 7*k; rf[2][l] = 200 - 45*l - 11*k; end
            rsel[1] = 2; rsel[2] = 1; rsel[3] = NREG + 1;
            abdot = k[0]; cddot = k[1]; rmux = k[2];
            rscale = k % 6;
            run("R5_R8");
        end

        // R9 R10: every scale code, with saturation
        for (int c = 0; c < 8; c++) begin
            for (int v = -256; v <= 256; v += 32) begin
                base();
                for (int l = 0; l < 4; l++) rf[1][l] = v;
                rscale = c; ascale = c;
                run("R9_R10");
            end
        end

        // R3: source codes, alpha replicate, blue select
        for (int s = 0; s < NREG + 2; s++) begin
            for (int f = 0; f < 2; f++) begin
                base();
                rsel[0] = s; ralpha[0] = f[0]; asel[0] = s; ablue[0] = f[0];
                rsel[3] = s; ralpha[3] = !f[0]; rsel[2] = 4;
                asel[2] = s; asel[3] = NREG + 1; ablue[2] = !f[0];
                run("R3");
            end
        end

        // R7 R11: mux steered by the spare alpha around the 0.5 threshold
        begin
            int sp [7] = '{-256, 0, 126, 127, 128, 129, 256};
            for (int k = 0; k < 7; k++) begin
                for (int mx = 0; mx < 2; mx++) begin
                    base();
                    rf[SPARE][3] = sp[k];
                    rsel[2] = 3; rsel[3] = 4; asel[2] = 3; asel[3] = 5;
                    rmux = mx[0]; amux = mx[0];
                    run("R7_R11");
                end
            end
        end

        // R2: idle cycle holds results
        base();
        rscale = 1; rsel[2] = 2;
        run("R2");
        @(negedge clk);
        rsel = '{3, 4, 5, NREG + 1}; rscale = 2; abdot = 1; drive();
        in_valid = 1'b0;
        @(negedge clk);
        compare_all("R2 hold");
        cmp("R2 hold", "valid", int'(out_valid), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule